// File: doc/BRIEF.md
# SD Host Port Power-State Controller

This block keeps the power state of one SD/MMC host port and decides what the card-facing pads do in each state. A register write carries a 2-bit power mode and a transceiver direction-polarity bit. From these the block drives the output enables and output values for the clock pad, the command pad and up to eight data pads. It also drives the direction controls of an external level-shifting transceiver and a qualifier that tells the clock and command logic when the interface may run.

There are three live modes. Power-off holds every line high with the interface disabled. Power-cycle pulls every line low, so the card cannot be supplied through its signal pins. Power-on runs the card clock from the host core at once, but keeps command and data lines idle-high and the interface disabled until a fixed number of card-clock cycles has gone by. Card-clock cycles are seen as a one-cycle tick input, so the hold-off only advances while the card clock actually toggles. The reset mode uses the same code as power-off.

Top module: `sdpwr_ctrl`

## Requirements
- R1: After reset the mode output reads 00 (power-off), the polarity bit is 0, and both holdoff_done_o and if_en_o are 0.
- R2: A write with reg_wdata_i[1:0] equal to 00, 10 or 11 makes pwr_state_o show that code from the cycle after the write.
- R3: A write with reg_wdata_i[1:0] equal to 01 leaves the mode unchanged; the polarity bit of that write is still taken.
- R4: In power-off (00) every pad (clock, command, all data lines) has output enable 1 and output value 1, and if_en_o is 0.
- R5: In power-cycle (10) every pad has output enable 1 and output value 0, and if_en_o is 0.
- R6: In power-on (11) the clock pad is enabled and follows core_ck_i; until the hold-off completes, command and data pads are enabled and held at 1, and if_en_o is 0.
- R7: The hold-off completes once HOLD_CLKS (default 74) card-clock ticks have been counted in power-on: holdoff_done_o and if_en_o go to 1 in the cycle after the tick that completes the count, and command and data pads then follow the core inputs.
- R8: Ticks arriving outside power-on, or cycles with card_tick_i low, do not advance the hold-off.
- R9: Writing 11 again while already in power-on does not restart the hold-off; leaving power-on and entering it again restarts it from zero.
- R10: The polarity bit is reg_wdata_i[4]; xcvr_dir_cmd_o equals the command pad enable XOR the polarity bit, and xcvr_dir_dat_o equals the data line 0 pad enable XOR the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Power register write strobe |
| reg_wdata_i | input | 5 | Write data: [1:0] power mode, [4] direction polarity |
| card_tick_i | input | 1 | One pulse per card-clock cycle |
| core_ck_i | input | 1 | Card clock value from the clock generator |
| core_cmd_oe_i | input | 1 | Command output enable from the core |
| core_cmd_do_i | input | 1 | Command output value from the core |
| core_dat_oe_i | input | DAT_W | Data output enables from the core |
| core_dat_do_i | input | DAT_W | Data output values from the core |
| pad_ck_oe_o | output | 1 | Clock pad output enable |
| pad_ck_do_o | output | 1 | Clock pad output value |
| pad_cmd_oe_o | output | 1 | Command pad output enable |
| pad_cmd_do_o | output | 1 | Command pad output value |
| pad_dat_oe_o | output | DAT_W | Data pad output enables |
| pad_dat_do_o | output | DAT_W | Data pad output values |
| xcvr_dir_cmd_o | output | 1 | Transceiver direction for the command line |
| xcvr_dir_dat_o | output | 1 | Transceiver direction for the data lines |
| if_en_o | output | 1 | Interface enable for clock and command logic |
| pwr_state_o | output | 2 | Current power mode |
| holdoff_done_o | output | 1 | Hold-off after power-on complete |

## Verification
A wrong mode register shows at once on pwr_state_o and on every pad in the cycle after the write, since the pad levels are a direct function of the mode; a sweep of every code from every starting mode under both polarities catches it. A hold-off counter that is off by one, counts without ticks, or fails to restart shows as holdoff_done_o and if_en_o rising one tick early or late, or as command and data pads leaving their idle-high level at the wrong time; the bench samples the tick before and the tick at the boundary of each count.

// File: rtl/sdpwr_pkg.sv
package sdpwr_pkg;
  typedef enum logic [1:0] {
    PWR_OFF   = 2'b00,
    PWR_RSVD  = 2'b01,
    PWR_CYCLE = 2'b10,
    PWR_ON    = 2'b11
  } pwr_mode_e;

  localparam int WDATA_W = 5;
  localparam int POL_BIT = 4;
endpackage

// File: rtl/sdpwr_state.sv
module sdpwr_state
  import sdpwr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic [1:0] wr_mode_i,
  input  logic      wr_pol_i,
  output pwr_mode_e mode_o,
  output logic      pol_o
);
  pwr_mode_e mode_q, mode_d;
  logic      pol_q, pol_d;
  logic      mode_ok;

  // reserved code leaves the mode as it is
  assign mode_ok = (wr_mode_i != PWR_RSVD);

  always_comb begin
    mode_d = mode_q;
    pol_d  = pol_q;
    if (wr_en_i) begin
      pol_d = wr_pol_i;
      if (mode_ok) mode_d = pwr_mode_e'(wr_mode_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PWR_OFF;
      pol_q  <= 1'b0;
    end else if (wr_en_i) begin
      mode_q <= mode_d;
      pol_q  <= pol_d;
    end
  end

  assign mode_o = mode_q;
  assign pol_o  = pol_q;

  // R3: reserved write keeps mode
  a_r3_rsvd_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_mode_i == 2'b01) |=> $stable(mode_q));
  // R2: no write, no change
  a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mode_q) && $stable(pol_q)));
  // R2: reserved code never stored
  a_r2_never_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != PWR_RSVD);
endmodule

// File: rtl/sdpwr_holdoff.sv
module sdpwr_holdoff #(
  parameter int HOLD_CLKS = 74
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(HOLD_CLKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_max;

  assign at_max = (cnt_q == CNT_MAX);

  // clear whenever power-on is left, so the next entry starts from zero
  assign cnt_en = !on_i || (tick_i && !at_max);

  always_comb begin
    cnt_d = cnt_q;
    if (!on_i)       cnt_d = '0;
    else if (tick_i && !at_max) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = on_i && at_max;

  // R7: counter never passes the limit
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  // R8: no tick, no progress while on
  a_r8_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i && !tick_i) |=> (cnt_q == $past(cnt_q)) || !on_i);
  // R9: count is zero right after entering power-on
  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_i) |-> cnt_q == '0);
  // R7: done stays while on
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && on_i) |=> (done_o || !on_i));
endmodule

// File: rtl/sdpwr_padmux.sv
module sdpwr_padmux
  import sdpwr_pkg::*;
#(
  parameter int DAT_W = 8
) (
  input  pwr_mode_e        mode_i,
  input  logic             pol_i,
  input  logic             done_i,
  input  logic             core_ck_i,
  input  logic             core_cmd_oe_i,
  input  logic             core_cmd_do_i,
  input  logic [DAT_W-1:0] core_dat_oe_i,
  input  logic [DAT_W-1:0] core_dat_do_i,
  output logic             ck_oe_o,
  output logic             ck_do_o,
  output logic             cmd_oe_o,
  output logic             cmd_do_o,
  output logic [DAT_W-1:0] dat_oe_o,
  output logic [DAT_W-1:0] dat_do_o,
  output logic             dir_cmd_o,
  output logic             dir_dat_o
);
  logic live;    // core owns command and data lines
  logic level;   // forced level when the core does not own them

  assign live  = (mode_i == PWR_ON) && done_i;
  assign level = (mode_i != PWR_CYCLE);

  always_comb begin
    ck_oe_o = 1'b1;
    unique case (mode_i)
      PWR_ON:    ck_do_o = core_ck_i;
      PWR_CYCLE: ck_do_o = 1'b0;
      default:   ck_do_o = 1'b1;
    endcase
  end

  assign cmd_oe_o = live ? core_cmd_oe_i : 1'b1;
  assign cmd_do_o = live ? core_cmd_do_i : level;

  for (genvar g = 0; g < DAT_W; g++) begin : g_dat
    assign dat_oe_o[g] = live ? core_dat_oe_i[g] : 1'b1;
    assign dat_do_o[g] = live ? core_dat_do_i[g] : level;
  end

  assign dir_cmd_o = cmd_oe_o ^ pol_i;
  assign dir_dat_o = dat_oe_o[0] ^ pol_i;
endmodule

// File: rtl/sdpwr_ctrl.sv
module sdpwr_ctrl
  import sdpwr_pkg::*;
#(
  parameter int DAT_W     = 8,
  parameter int HOLD_CLKS = 74
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [4:0]       reg_wdata_i,
  input  logic             card_tick_i,
  input  logic             core_ck_i,
  input  logic             core_cmd_oe_i,
  input  logic             core_cmd_do_i,
  input  logic [DAT_W-1:0] core_dat_oe_i,
  input  logic [DAT_W-1:0] core_dat_do_i,
  output logic             pad_ck_oe_o,
  output logic             pad_ck_do_o,
  output logic             pad_cmd_oe_o,
  output logic             pad_cmd_do_o,
  output logic [DAT_W-1:0] pad_dat_oe_o,
  output logic [DAT_W-1:0] pad_dat_do_o,
  output logic             xcvr_dir_cmd_o,
  output logic             xcvr_dir_dat_o,
  output logic             if_en_o,
  output logic [1:0]       pwr_state_o,
  output logic             holdoff_done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  pwr_mode_e  mode;
  logic       pol;
  logic       done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sdpwr_state u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (reg_we_i),
    .wr_mode_i (reg_wdata_i[1:0]),
    .wr_pol_i  (reg_wdata_i[POL_BIT]),
    .mode_o    (mode),
    .pol_o     (pol)
  );

  sdpwr_holdoff #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .on_i   (mode == PWR_ON),
    .tick_i (card_tick_i),
    .done_o (done)
  );

  sdpwr_padmux #(.DAT_W(DAT_W)) u_pad (
    .mode_i        (mode),
    .pol_i         (pol),
    .done_i        (done),
    .core_ck_i     (core_ck_i),
    .core_cmd_oe_i (core_cmd_oe_i),
    .core_cmd_do_i (core_cmd_do_i),
    .core_dat_oe_i (core_dat_oe_i),
    .core_dat_do_i (core_dat_do_i),
    .ck_oe_o       (pad_ck_oe_o),
    .ck_do_o       (pad_ck_do_o),
    .cmd_oe_o      (pad_cmd_oe_o),
    .cmd_do_o      (pad_cmd_do_o),
    .dat_oe_o      (pad_dat_oe_o),
    .dat_do_o      (pad_dat_do_o),
    .dir_cmd_o     (xcvr_dir_cmd_o),
    .dir_dat_o     (xcvr_dir_dat_o)
  );

  assign pwr_state_o    = mode;
  assign holdoff_done_o = done;
  assign if_en_o        = done;

  // R4: power-off pads all high
  a_r4_off_high: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pwr_state_o == 2'b00) |-> (pad_ck_do_o && pad_cmd_do_o && (&pad_dat_do_o)
                                && (&pad_dat_oe_o) && !if_en_o));
  // R5: power-cycle pads all low
  a_r5_cycle_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pwr_state_o == 2'b10) |-> (!pad_ck_do_o && !pad_cmd_do_o && (pad_dat_do_o == '0)
                                && (&pad_dat_oe_o) && !if_en_o));
  // R6: interface held off outside a completed power-on
  a_r6_en_needs_on: assert property (@(posedge clk_i) disable iff (!rst_n)
    if_en_o |-> (pwr_state_o == 2'b11));
  // R6: held-off command line idles high
  a_r6_idle_cmd: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pwr_state_o == 2'b11 && !holdoff_done_o) |-> (pad_cmd_oe_o && pad_cmd_do_o));
endmodule

// File: tb/sim_sdpwr_ctrl.sv
`timescale 1ns/1ps
module sim_sdpwr_ctrl;
  localparam int DW = 8;
  localparam int HOLD = 74;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] wdata = '0;
  logic tick = 1'b0;
  logic cck = 1'b0;
  logic c_cmd_oe = 1'b0, c_cmd_do = 1'b0;
  logic [DW-1:0] c_dat_oe = '0, c_dat_do = '0;
  logic ck_oe, ck_do, cmd_oe, cmd_do, dir_cmd, dir_dat, if_en, done;
  logic [DW-1:0] dat_oe, dat_do;
  logic [1:0] st;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sdpwr_ctrl #(.DAT_W(DW), .HOLD_CLKS(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .card_tick_i(tick), .core_ck_i(cck), .core_cmd_oe_i(c_cmd_oe),
    .core_cmd_do_i(c_cmd_do), .core_dat_oe_i(c_dat_oe), .core_dat_do_i(c_dat_do),
    .pad_ck_oe_o(ck_oe), .pad_ck_do_o(ck_do), .pad_cmd_oe_o(cmd_oe),
    .pad_cmd_do_o(cmd_do), .pad_dat_oe_o(dat_oe), .pad_dat_do_o(dat_do),
    .xcvr_dir_cmd_o(dir_cmd), .xcvr_dir_dat_o(dir_dat), .if_en_o(if_en),
    .pwr_state_o(st), .holdoff_done_o(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one register write, returns sampled at the following falling edge
  task automatic wr(input logic [1:0] m, input logic p);
    @(negedge clk);
    we = 1'b1; wdata = {p, 2'b00, m};
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  // full pad comparison from mode, hold-off status and polarity
  task automatic pads(input string req, input logic [1:0] m, input logic dn, input logic p);
    logic live, lvl, e_cmd_oe, e_cmd_do, e_ck;
    logic [DW-1:0] e_doe, e_ddo;
    live = (m == 2'b11) && dn;
    lvl  = (m != 2'b10);
    e_ck = (m == 2'b11) ? cck : lvl;
    e_cmd_oe = live ? c_cmd_oe : 1'b1;
    e_cmd_do = live ? c_cmd_do : lvl;
    e_doe = live ? c_dat_oe : '1;
    e_ddo = live ? c_dat_do : {DW{lvl}};
    chk({req, " state"}, 64'(st), 64'(m));
    chk({req, " ck"}, 64'({ck_oe, ck_do}), 64'({1'b1, e_ck}));
    chk({req, " cmd"}, 64'({cmd_oe, cmd_do}), 64'({e_cmd_oe, e_cmd_do}));
    chk({req, " dat"}, 64'({dat_oe, dat_do}), 64'({e_doe, e_ddo}));
    chk({req, " R10 dir"}, 64'({dir_cmd, dir_dat}), 64'({e_cmd_oe ^ p, e_doe[0] ^ p}));
    chk({req, " en"}, 64'({if_en, done}), 64'({live, live}));
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [1:0] starts [3];
    starts[0] = 2'b00; starts[1] = 2'b10; starts[2] = 2'b11;
    c_cmd_oe = 1'b0; c_cmd_do = 1'b1; c_dat_oe = 8'hA5; c_dat_do = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, also R4 power-off pads
    pads("R1 R4 reset", 2'b00, 1'b0, 1'b0);

    // R2 R3 R4 R5 R6 R10 sweep: every start mode, every code, both polarities
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 2; p++) begin
          logic [1:0] exp_m;
          wr(starts[s], 1'b0);
          wr(2'(c), 1'(p));
          exp_m = (c == 1) ? starts[s] : 2'(c);
          pads((c == 1) ? "R3 rsvd" : "R2 write", exp_m, 1'b0, 1'(p));
          cck = ~cck;
          #0.1;
          pads("R6 ck follows", exp_m, 1'b0, 1'(p));
        end

    // R8: ticks in off and cycle do not count
    wr(2'b00, 1'b0);
    ticks(HOLD + 5);
    wr(2'b10, 1'b0);
    ticks(HOLD + 5);
    wr(2'b11, 1'b0);
    pads("R8 no carry-in", 2'b11, 1'b0, 1'b0);

    // R7 boundary: 73 ticks not enough, the 74th completes
    ticks(HOLD - 1);
    pads("R7 before limit", 2'b11, 1'b0, 1'b0);
    // R8: idle cycles without tick do not advance
    repeat (20) @(negedge clk);
    pads("R8 idle", 2'b11, 1'b0, 1'b0);
    ticks(1);
    pads("R7 at limit", 2'b11, 1'b1, 1'b0);
    c_cmd_oe = 1'b1; c_cmd_do = 1'b0; c_dat_oe = 8'h5A; c_dat_do = 8'hC3;
    #0.1;
    pads("R7 core pass", 2'b11, 1'b1, 1'b0);

    // R9: rewriting power-on keeps completion
    wr(2'b11, 1'b1);
    pads("R9 rewrite on", 2'b11, 1'b1, 1'b1);
    // R3: reserved write while on keeps completion, polarity taken
    wr(2'b01, 1'b0);
    pads("R3 rsvd on", 2'b11, 1'b1, 1'b0);

    // R9: leave and re-enter restarts the count
    wr(2'b00, 1'b0);
    pads("R9 left", 2'b00, 1'b0, 1'b0);
    wr(2'b11, 1'b0);
    pads("R9 reentry", 2'b11, 1'b0, 1'b0);
    ticks(HOLD - 1);
    pads("R9 reentry before", 2'b11, 1'b0, 1'b0);
    ticks(1);
    pads("R9 reentry done", 2'b11, 1'b1, 1'b0);

    // R9: power-cycle then on also restarts
    wr(2'b10, 1'b1);
    pads("R5 cycle after on", 2'b10, 1'b0, 1'b1);
    wr(2'b11, 1'b1);
    ticks(10);
    pads("R9 partial", 2'b11, 1'b0, 1'b1);

    // R1: reset mid-run returns to power-off
    rst_n = 1'b0;
    #1;
    pads("R1 async reset", 2'b00, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pads("R1 after release", 2'b00, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule